// File: doc/BRIEF.md
# Planar Video Memory Raster-Operation Write Unit

This block turns writes from a CPU-side port into per-plane byte writes to a video memory that is split into bit planes. It handles byte writes and 16-bit writes. Each memory column holds one byte per plane. The physical byte address of a plane is the column address shifted left by the plane-index width, with the plane number in the low bits. The unit reads the current bytes of every plane at a column, computes a new byte for each plane and writes the results back in a single cycle. Each plane has its own write strobe.

Three write modes are supported. In the logic mode, CPU data (or a replicated set/reset bit) passes through a raster function together with the plane's latched source byte. A pixel bit mask then merges the result with the byte already in memory. In the expand mode, bit `p` of the CPU data fills plane `p` with ones or zeros, and the result is merged with the latched byte. In the latch-copy mode, the latched bytes are stored as they are. The latched source data comes in on a port, because the read path that captures it is outside this block. A 16-bit write puts its high byte one column (one plane-group) above its low byte. Every address wraps through the memory size.

Top module: `planar_rop_writer`

## Requirements
- R1: The low-byte column write goes to memory byte address `(col << 3) mod 2^MEM_AW`, with plane `p` at that address plus `p`, so `mem_addr` has its three low bits zero. Column values beyond the memory alias into it instead of being dropped. The word high byte goes to `((col << 3) + 8) mod 2^MEM_AW`, so the top column wraps to address 0.
- R2: `cpu_ready` is high only when the unit is idle, and a command is accepted on a rising edge where `cpu_valid` and `cpu_ready` are both high. In the cycle after acceptance, `mem_re` is high with `mem_we` at zero. In the next cycle the write strobes are driven at the same `mem_addr`. A byte write returns to ready in the cycle after that. A word write repeats the read/write pair for the high byte and then returns to ready.
- R3: `cpu_rop` selects the raster function between the plane input and the latched byte of that plane: 0 passes the input, 1 is AND, 2 is OR, 3 is XOR.
- R4: In logic mode (`cpu_wmode` = 0), result bits where the bit mask is 1 take the raster result, and bits where the mask is 0 keep the byte currently in memory.
- R5: In logic mode, with mask all ones, raster function 0 and no set/reset enable, the CPU byte is written unchanged to every enabled plane.
- R6: In modes 0 and 1, when `cpu_sr_en[p]` is set, the input of plane `p` is `cpu_sr_val[p]` replicated across the byte, in place of the CPU data.
- R7: In expand mode (`cpu_wmode` = 1), the input of plane `p` is `cpu_data[p]` replicated across the byte (for both halves of a word). After the raster function, the bit mask merges the result with the latched byte of the plane, not with memory.
- R8: In latch-copy mode (`cpu_wmode` = 2), each enabled plane receives its latched byte. CPU data, raster function and bit mask have no effect.
- R9: Mode 3 is reserved. It runs the same handshake timing but raises no write strobe and leaves memory unchanged.
- R10: A plane whose `cpu_plane_en` bit is clear gets no write strobe, and its memory bytes stay bit-exact.
- R11: When `cpu_word` is 1, the low write uses data, mask and latch bits [7:0] and the high write uses bits [15:8]. Plane `p` latch bits sit at `cpu_latch[16p +: 16]`, and plane `p` memory bytes sit at `mem_wdata/mem_rdata[8p +: 8]`.
- R12: Synchronous active-high reset returns the unit to idle with ready high and no strobes. Memory contents are never touched by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Write command offered |
| cpu_ready | output | 1 | Unit idle, command taken this edge if valid |
| cpu_col | input | COL_W | Column address (unshifted) |
| cpu_word | input | 1 | 1 = 16-bit write spanning two columns |
| cpu_wmode | input | 2 | 0 logic, 1 expand, 2 latch copy, 3 reserved |
| cpu_rop | input | 2 | Raster function: 0 pass, 1 AND, 2 OR, 3 XOR |
| cpu_data | input | 16 | CPU write data (low byte for byte writes) |
| cpu_bitmask | input | 16 | Pixel bit mask, 1 = take computed bit |
| cpu_plane_en | input | PLANES | Per-plane write enable |
| cpu_sr_en | input | PLANES | Per-plane set/reset enable |
| cpu_sr_val | input | PLANES | Per-plane set/reset value |
| cpu_latch | input | 16*PLANES | Latched source data, 16 bits per plane |
| mem_re | output | 1 | Memory read strobe, data due next cycle |
| mem_we | output | PLANES | Per-plane memory write strobe |
| mem_addr | output | MEM_AW | Plane-0 byte address of the column being accessed |
| mem_wdata | output | 8*PLANES | Write bytes, one per plane |
| mem_rdata | input | 8*PLANES | Read bytes, one per plane, one cycle after mem_re |

## Verification
A command accepted on edge E0 raises the read strobe in the cycle after E0. The plane write strobes and the write address are due in the cycle after edge E1. For a word, the high-byte read and write follow after edges E2 and E3. Ready is back after edge E2 for a byte and after edge E4 for a word. The bench drives and samples on falling clock edges and checks each of these signals in exactly that slot. Once ready is back, it compares the whole memory image with a behavioural reference that applies the requirement rules byte by byte.

// File: rtl/planar_rop_pkg.sv
package planar_rop_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      WM_LOGIC  = 2'd0,
      WM_EXPAND = 2'd1,
      WM_LATCH  = 2'd2,
      WM_NONE   = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      ROP_PASS = 2'd0,
      ROP_AND  = 2'd1,
      ROP_OR   = 2'd2,
      ROP_XOR  = 2'd3
   } rop_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_e;

   function automatic logic [BYTE_W-1:0] rop_apply(input rop_e fn,
                                                   input logic [BYTE_W-1:0] a,
                                                   input logic [BYTE_W-1:0] b);
      case (fn)
         ROP_AND: rop_apply = a & b;
         ROP_OR:  rop_apply = a | b;
         ROP_XOR: rop_apply = a ^ b;
         default: rop_apply = a;
      endcase
   endfunction

endpackage

// File: rtl/planar_rop_lane.sv
module planar_rop_lane
   import planar_rop_pkg::*;
(
   input  wmode_e            mode,
   input  rop_e              rop,
   input  logic [BYTE_W-1:0] cpu_b,
   input  logic              cpu_bit,
   input  logic              sr_en,
   input  logic              sr_val,
   input  logic [BYTE_W-1:0] mask_b,
   input  logic [BYTE_W-1:0] latch_b,
   input  logic [BYTE_W-1:0] cur_b,
   output logic [BYTE_W-1:0] res_b
);

   logic [BYTE_W-1:0] src;
   logic [BYTE_W-1:0] fres;
   logic [BYTE_W-1:0] keep;

   always_comb begin
      src = (mode == WM_EXPAND) ? {BYTE_W{cpu_bit}} : cpu_b;
      if (sr_en)
         src = {BYTE_W{sr_val}};
      fres = rop_apply(rop, src, latch_b);
      keep = (mode == WM_EXPAND) ? latch_b : cur_b;
      if (mode == WM_LATCH)
         res_b = latch_b;
      else
         res_b = (fres & mask_b) | (keep & ~mask_b);
   end

endmodule

// File: rtl/planar_rop_addr.sv
module planar_rop_addr #(
   parameter int COL_W  = 8,
   parameter int MEM_AW = 10,
   parameter int PLANES = 8
) (
   input  logic [COL_W-1:0]  col,
   input  logic              hi,
   output logic [MEM_AW-1:0] base
);

   localparam int PL_W  = $clog2(PLANES);
   localparam int LIN_W = ((COL_W + PL_W) > MEM_AW ? (COL_W + PL_W) : MEM_AW) + 1;
   localparam logic [LIN_W-1:0] WRAP_MASK = LIN_W'((64'd1 << MEM_AW) - 64'd1);

   logic [LIN_W-1:0] lin;

   always_comb begin
      lin = LIN_W'(col) << PL_W;
      if (hi)
         lin = lin + LIN_W'(PLANES);
   end

   assign base = MEM_AW'(lin & WRAP_MASK);

endmodule

// File: rtl/planar_rop_seq.sv
module planar_rop_seq
   import planar_rop_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic word_q,
   output logic ready,
   output logic accept,
   output logic rd_slot,
   output logic wr_slot,
   output logic hi
);

   seq_e state;

   assign ready   = (state == ST_IDLE);
   assign accept  = ready && in_valid;
   assign rd_slot = (state == ST_READ);
   assign wr_slot = (state == ST_WRITE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         hi    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (in_valid) begin
               state <= ST_READ;
               hi    <= 1'b0;
            end
            ST_READ: state <= ST_WRITE;
            ST_WRITE: if (word_q && !hi) begin
               state <= ST_READ;
               hi    <= 1'b1;
            end else begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/planar_rop_writer.sv
module planar_rop_writer
   import planar_rop_pkg::*;
#(
   parameter int PLANES = 8,
   parameter int COL_W  = 8,
   parameter int MEM_AW = 10
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cpu_valid,
   output logic                       cpu_ready,
   input  logic [COL_W-1:0]           cpu_col,
   input  logic                       cpu_word,
   input  logic [1:0]                 cpu_wmode,
   input  logic [1:0]                 cpu_rop,
   input  logic [WORD_W-1:0]          cpu_data,
   input  logic [WORD_W-1:0]          cpu_bitmask,
   input  logic [PLANES-1:0]          cpu_plane_en,
   input  logic [PLANES-1:0]          cpu_sr_en,
   input  logic [PLANES-1:0]          cpu_sr_val,
   input  logic [WORD_W*PLANES-1:0]   cpu_latch,
   output logic                       mem_re,
   output logic [PLANES-1:0]          mem_we,
   output logic [MEM_AW-1:0]          mem_addr,
   output logic [BYTE_W*PLANES-1:0]   mem_wdata,
   input  logic [BYTE_W*PLANES-1:0]   mem_rdata
);

   localparam int PL_W = $clog2(PLANES);

   if (PLANES < 2 || (1 << PL_W) != PLANES) begin : g_bad_planes
      $error("PLANES must be a power of two, at least 2");
   end
   if (PLANES > BYTE_W) begin : g_bad_expand
      $error("expand mode needs one CPU data bit per plane");
   end
   if (MEM_AW <= PL_W) begin : g_bad_aw
      $error("MEM_AW must exceed the plane index width");
   end

   // captured command; only the sequencer state is reset
   logic [COL_W-1:0]         q_col;
   logic                     q_word;
   wmode_e                   q_mode;
   rop_e                     q_rop;
   logic [WORD_W-1:0]        q_data;
   logic [WORD_W-1:0]        q_mask;
   logic [PLANES-1:0]        q_plane_en;
   logic [PLANES-1:0]        q_sr_en;
   logic [PLANES-1:0]        q_sr_val;
   logic [WORD_W*PLANES-1:0] q_latch;

   logic accept, rd_slot, wr_slot, hi;

   planar_rop_seq u_seq (
      .clk      (clk),
      .rst      (rst),
      .in_valid (cpu_valid),
      .word_q   (q_word),
      .ready    (cpu_ready),
      .accept   (accept),
      .rd_slot  (rd_slot),
      .wr_slot  (wr_slot),
      .hi       (hi)
   );

   always_ff @(posedge clk) begin
      if (accept) begin
         q_col      <= cpu_col;
         q_word     <= cpu_word;
         q_mode     <= wmode_e'(cpu_wmode);
         q_rop      <= rop_e'(cpu_rop);
         q_data     <= cpu_data;
         q_mask     <= cpu_bitmask;
         q_plane_en <= cpu_plane_en;
         q_sr_en    <= cpu_sr_en;
         q_sr_val   <= cpu_sr_val;
         q_latch    <= cpu_latch;
      end
   end

   planar_rop_addr #(
      .COL_W  (COL_W),
      .MEM_AW (MEM_AW),
      .PLANES (PLANES)
   ) u_addr (
      .col  (q_col),
      .hi   (hi),
      .base (mem_addr)
   );

   logic [BYTE_W-1:0] half_data;
   logic [BYTE_W-1:0] half_mask;

   assign half_data = hi ? q_data[WORD_W-1:BYTE_W] : q_data[BYTE_W-1:0];
   assign half_mask = hi ? q_mask[WORD_W-1:BYTE_W] : q_mask[BYTE_W-1:0];

   for (genvar p = 0; p < PLANES; p++) begin : g_lane
      logic [BYTE_W-1:0] latch_b;
      assign latch_b = hi ? q_latch[p*WORD_W+BYTE_W +: BYTE_W]
                          : q_latch[p*WORD_W +: BYTE_W];
      planar_rop_lane u_lane (
         .mode    (q_mode),
         .rop     (q_rop),
         .cpu_b   (half_data),
         .cpu_bit (q_data[p]),
         .sr_en   (q_sr_en[p]),
         .sr_val  (q_sr_val[p]),
         .mask_b  (half_mask),
         .latch_b (latch_b),
         .cur_b   (mem_rdata[p*BYTE_W +: BYTE_W]),
         .res_b   (mem_wdata[p*BYTE_W +: BYTE_W])
      );
   end

   assign mem_re = rd_slot;
   assign mem_we = (wr_slot && q_mode != WM_NONE) ? q_plane_en : '0;

endmodule

// File: rtl/planar_rop_writer_chk.sv
module planar_rop_writer_chk #(
   parameter int PLANES = 8,
   parameter int MEM_AW = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_valid,
   input logic              cpu_ready,
   input logic              mem_re,
   input logic [PLANES-1:0] mem_we,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [PLANES-1:0] q_plane_en,
   input logic [1:0]        q_mode
);

   // R2
   accept_then_read_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_valid && cpu_ready) |=> (mem_re && mem_we == '0));

   // R2
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_re || mem_we != '0) |-> !cpu_ready);

   // R2
   write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_we != '0) |-> $past(mem_re));

   // R1
   addr_held_chk: assert property (@(posedge clk) disable iff (rst)
      mem_re |=> $stable(mem_addr));

   // R10
   strobe_enabled_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_we & ~q_plane_en) == '0);

   // R9
   reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (q_mode == 2'd3) |-> (mem_we == '0));

   // R12
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (cpu_ready && !mem_re && mem_we == '0));

endmodule

bind planar_rop_writer planar_rop_writer_chk #(
   .PLANES (PLANES),
   .MEM_AW (MEM_AW)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cpu_valid  (cpu_valid),
   .cpu_ready  (cpu_ready),
   .mem_re     (mem_re),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .q_plane_en (q_plane_en),
   .q_mode     (q_mode)
);

// File: tb/planar_rop_writer_tb.sv
module planar_rop_writer_tb;

   localparam int PLANES = 8;
   localparam int COL_W  = 8;
   localparam int MEM_AW = 10;
   localparam int MEMB   = 1 << MEM_AW;

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic                   cpu_valid = 1'b0;
   logic                   cpu_ready;
   logic [COL_W-1:0]       cpu_col = '0;
   logic                   cpu_word = 1'b0;
   logic [1:0]             cpu_wmode = '0;
   logic [1:0]             cpu_rop = '0;
   logic [15:0]            cpu_data = '0;
   logic [15:0]            cpu_bitmask = '0;
   logic [PLANES-1:0]      cpu_plane_en = '0;
   logic [PLANES-1:0]      cpu_sr_en = '0;
   logic [PLANES-1:0]      cpu_sr_val = '0;
   logic [16*PLANES-1:0]   cpu_latch = '0;
   logic                   mem_re;
   logic [PLANES-1:0]      mem_we;
   logic [MEM_AW-1:0]      mem_addr;
   logic [8*PLANES-1:0]    mem_wdata;
   logic [8*PLANES-1:0]    mem_rdata = '0;

   always #4 clk = ~clk;

   planar_rop_writer #(.PLANES(PLANES), .COL_W(COL_W), .MEM_AW(MEM_AW)) u_dut (
      .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
      .cpu_col(cpu_col), .cpu_word(cpu_word), .cpu_wmode(cpu_wmode),
      .cpu_rop(cpu_rop), .cpu_data(cpu_data), .cpu_bitmask(cpu_bitmask),
      .cpu_plane_en(cpu_plane_en), .cpu_sr_en(cpu_sr_en), .cpu_sr_val(cpu_sr_val),
      .cpu_latch(cpu_latch), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   logic [7:0] vmem    [MEMB];
   logic [7:0] ref_mem [MEMB];

   always @(posedge clk) begin
      for (int p = 0; p < PLANES; p++) begin
         if (mem_re)
            mem_rdata[p*8 +: 8] <= vmem[int'(mem_addr) + p];
         if (mem_we[p])
            vmem[int'(mem_addr) + p] <= mem_wdata[p*8 +: 8];
      end
   end

   int n_cmp = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_mem(input string req);
      int bad_at = -1;
      for (int a = 0; a < MEMB; a++)
         if (bad_at < 0 && vmem[a] !== ref_mem[a]) bad_at = a;
      if (bad_at < 0) check(1'b1, req, 0, 0);
      else check(1'b0, $sformatf("%s mem[%0d]", req, bad_at),
                 64'(vmem[bad_at]), 64'(ref_mem[bad_at]));
   endtask

   function automatic logic [7:0] exp_byte(input int mode, input int rop,
         input logic [7:0] d, input logic [7:0] m, input logic [7:0] l,
         input logic [7:0] cur, input logic bitp, input logic sre, input logic srv);
      logic [7:0] in_b, f;
      in_b = (mode == 1) ? (bitp ? 8'hff : 8'h00) : d;
      if (sre) in_b = srv ? 8'hff : 8'h00;
      case (rop)
         1: f = in_b & l;
         2: f = in_b | l;
         3: f = in_b ^ l;
         default: f = in_b;
      endcase
      if (mode == 2) return l;
      if (mode == 1) return (f & m) | (l & ~m);
      return (f & m) | (cur & ~m);
   endfunction

   function automatic logic [127:0] mk_latch(input int seed);
      logic [127:0] v;
      for (int p = 0; p < PLANES; p++)
         v[p*16 +: 16] = 16'((seed * 977 + p * 4441 + 16'h3c5a) ^ (p << 9));
      return v;
   endfunction

   task automatic run_op(input string tag, input int col, input bit word,
         input int mode, input int rop, input logic [15:0] data,
         input logic [15:0] mask, input logic [7:0] pen, input logic [7:0] sren,
         input logic [7:0] srval, input logic [127:0] latch);
      int nh = word ? 2 : 1;
      logic [7:0] exp_we = (mode == 3) ? 8'h00 : pen;
      @(negedge clk);
      cpu_col = COL_W'(col); cpu_word = word; cpu_wmode = 2'(mode);
      cpu_rop = 2'(rop); cpu_data = data; cpu_bitmask = mask;
      cpu_plane_en = pen; cpu_sr_en = sren; cpu_sr_val = srval; cpu_latch = latch;
      cpu_valid = 1'b1;
      check(cpu_ready === 1'b1, {"R2 ready idle ", tag}, 64'(cpu_ready), 1);
      @(posedge clk);
      for (int h = 0; h < nh; h++) begin
         int base = ((col * 8) + h * 8) % MEMB;
         @(negedge clk);
         cpu_valid = 1'b0;
         check(mem_re === 1'b1 && cpu_ready === 1'b0 && mem_we === '0,
               {"R2 read slot ", tag}, {mem_re, cpu_ready, mem_we}, {2'b10, 8'h00});
         @(negedge clk);
         check(mem_we === exp_we, {"R10 R9 strobes ", tag}, 64'(mem_we), 64'(exp_we));
         check(mem_addr === MEM_AW'(base), {"R1 R11 address ", tag},
               64'(mem_addr), 64'(base));
      end
      @(negedge clk);
      check(cpu_ready === 1'b1 && mem_re === 1'b0, {"R2 back to ready ", tag},
            {cpu_ready, mem_re}, 2'b10);
      for (int h = 0; h < nh; h++) begin
         int base = ((col * 8) + h * 8) % MEMB;
         for (int p = 0; p < PLANES; p++)
            if (exp_we[p])
               ref_mem[base + p] = exp_byte(mode, rop, data[h*8 +: 8], mask[h*8 +: 8],
                  latch[p*16 + h*8 +: 8], ref_mem[base + p], data[p], sren[p], srval[p]);
      end
      compare_mem(tag);
   endtask

   initial begin
      #(8 * 200000);
      check(1'b0, "R2 watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int a = 0; a < MEMB; a++) begin
         vmem[a]    = 8'((a * 37 + 11) ^ (a >> 3));
         ref_mem[a] = 8'((a * 37 + 11) ^ (a >> 3));
      end
      repeat (3) @(negedge clk);
      check(cpu_ready === 1'b1 && mem_re === 1'b0 && mem_we === '0,
            "R12 state in reset", {cpu_ready, mem_re, mem_we}, {2'b10, 8'h00});
      rst = 1'b0;
      @(negedge clk);
      check(cpu_ready === 1'b1 && mem_we === '0, "R12 idle after reset",
            {cpu_ready, mem_we}, {1'b1, 8'h00});

      run_op("R5 fast path",        5,   0, 0, 0, 16'h00a7, 16'h00ff, 8'hff, 8'h00, 8'h00, mk_latch(1));
      run_op("R3 R4 rop AND",       6,   0, 0, 1, 16'h005c, 16'h003c, 8'hff, 8'h00, 8'h00, mk_latch(2));
      run_op("R3 R10 rop OR",       7,   0, 0, 2, 16'h0091, 16'h00f0, 8'ha5, 8'h00, 8'h00, mk_latch(3));
      run_op("R3 R4 rop XOR",       8,   0, 0, 3, 16'h00e6, 16'h000f, 8'hff, 8'h00, 8'h00, mk_latch(4));
      run_op("R6 set reset",        9,   0, 0, 0, 16'h0033, 16'h00ff, 8'hff, 8'h0f, 8'h05, mk_latch(5));
      run_op("R7 expand plain",     11,  0, 1, 0, 16'h00c3, 16'h005a, 8'hff, 8'h00, 8'h00, mk_latch(6));
      run_op("R7 R6 expand XOR",    12,  0, 1, 3, 16'h0069, 16'h00e7, 8'hff, 8'h80, 8'h80, mk_latch(7));
      run_op("R8 latch copy",       13,  0, 2, 3, 16'h00ff, 16'h0000, 8'h7e, 8'hff, 8'h00, mk_latch(8));
      run_op("R9 reserved mode",    14,  0, 3, 2, 16'h00ff, 16'h00ff, 8'hff, 8'h00, 8'h00, mk_latch(9));
      run_op("R11 word OR",         20,  1, 0, 2, 16'h5aa5, 16'h0ff0, 8'hff, 8'h00, 8'h00, mk_latch(10));
      run_op("R1 R11 word top wrap",127, 1, 0, 1, 16'h1234, 16'hff81, 8'hdb, 8'h00, 8'h00, mk_latch(11));
      run_op("R1 column alias",     200, 0, 0, 0, 16'h004e, 16'h00ff, 8'hff, 8'h00, 8'h00, mk_latch(12));
      run_op("R8 R11 word latch",   30,  1, 2, 0, 16'hffff, 16'h0000, 8'hf0, 8'h00, 8'h00, mk_latch(13));
      run_op("R7 R11 word expand",  31,  1, 1, 2, 16'h00a6, 16'h3cc3, 8'hff, 8'h00, 8'h00, mk_latch(14));
      run_op("R10 no planes",       40,  0, 0, 0, 16'h0000, 16'h00ff, 8'h00, 8'h00, 8'h00, mk_latch(15));

      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      compare_mem("R12 memory kept over reset");
      run_op("R12 R4 after reset",  41,  0, 0, 3, 16'h00b2, 16'h0066, 8'h3c, 8'h00, 8'h00, mk_latch(16));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule